// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Unit

This block sits in the execute stage of a five-stage, in-order integer pipeline. It takes the two source register numbers of the instruction now in execute. It compares them with the destination register numbers of the two older instructions still in flight: one in the memory stage and one in the writeback stage. For each ALU operand it then produces a 2-bit select and the operand word that the select picks. That word is the register-file read value, the writeback-stage result, or the ALU result held in the memory-stage register.

The writeback-stage candidate is first resolved by a memory-to-register flag. The flag chooses between that stage's stored ALU result and its loaded memory word. When both older stages target the same source register, the younger instruction's result (the memory stage) takes precedence. This ensures that two back-to-back writes to a register are seen in order by a following reader. Register 0 is hard-wired to zero and is never bypassed.

The unit is purely combinational and holds no state. In the absence of a clock, the house-style state machine reduces to a fixed set of selection outcomes:
- REGFILE: code 0
- WB: code 1
- EXMEM: code 2

Each operand is resolved separately, and each operand's outcome follows only the priority rules below.

Top module: `fwd_unit`

## Requirements
- R1: An operand's select is 2 (memory-stage ALU result) when the memory-stage write enable is 1, the memory-stage destination equals that operand's source register, and that destination is nonzero.
- R2: An operand's select is 1 (writeback value) when the writeback-stage write enable is 1, its destination equals the operand's source register and is nonzero, and the condition of R1 does not hold for that operand.
- R3: When both older stages would qualify for the same operand, the select is 2, so the younger result wins.
- R4: A destination register number of 0 never causes a bypass, whatever the write enables are.
- R5: In every other case the select is 0 (register-file value), and select code 3 is never produced.
- R6: Each forwarded operand equals the register-file value for select 0, the writeback value for select 1 and the memory-stage ALU result for select 2.
- R7: The writeback value is the loaded memory word when the memory-to-register flag is 1 and the writeback-stage ALU result when it is 0.
- R8: Operand A (source `ex_rs`) and operand B (source `ex_rt`) are resolved independently, so both may bypass at once and from different stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs | input | 5 | First source register number of the instruction in execute |
| ex_rt | input | 5 | Second source register number of the instruction in execute |
| rf_a | input | 32 | Register-file read value for operand A |
| rf_b | input | 32 | Register-file read value for operand B |
| exm_wen | input | 1 | Memory-stage instruction will write a register |
| exm_rd | input | 5 | Memory-stage destination register number |
| exm_alu | input | 32 | ALU result held in the memory-stage register |
| mwb_wen | input | 1 | Writeback-stage instruction will write a register |
| mwb_rd | input | 5 | Writeback-stage destination register number |
| mwb_alu | input | 32 | ALU result held in the writeback-stage register |
| mwb_load | input | 32 | Loaded memory word held in the writeback-stage register |
| mwb_mem2reg | input | 1 | 1 selects the loaded word as writeback value, 0 the ALU result |
| sel_a | output | 2 | Select for operand A: 0 register file, 1 writeback, 2 memory stage |
| sel_b | output | 2 | Select for operand B, same encoding |
| opnd_a | output | 32 | Forwarded operand A |
| opnd_b | output | 32 | Forwarded operand B |

## Verification
All four results are due in the same cycle as the inputs that produce them, because no register lies between any input and any output. The bench applies a new vector just after each rising clock edge. It compares selects and operands with its behavioural model at the following falling edge, so every path has half a cycle to settle. The vectors sweep source and destination numbers over a set that includes register 0 and register 31, across every combination of the two write enables and the memory-to-register flag.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    // Operand source selection codes; value 3 is never generated.
    typedef enum logic [1:0] {
        FWD_REGFILE = 2'd0,
        FWD_WB      = 2'd1,
        FWD_EXMEM   = 2'd2
    } fwd_sel_e;

    localparam int unsigned FWD_OPERANDS = 2;

endpackage

// File: rtl/fwd_match.sv
module fwd_match
    import fwd_pkg::*;
#(
    parameter int unsigned REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic             exm_wen,
    input  logic [REG_W-1:0] exm_rd,
    input  logic             mwb_wen,
    input  logic [REG_W-1:0] mwb_rd,
    output fwd_sel_e         sel
);

    logic exm_hit;
    logic mwb_hit;

    // A stage qualifies only if it writes, targets this source, and is not r0.
    always_comb begin
        exm_hit = exm_wen && (exm_rd == src) && (exm_rd != '0);
        mwb_hit = mwb_wen && (mwb_rd == src) && (mwb_rd != '0);
    end

    // Younger stage (memory) has priority over the writeback stage.
    always_comb begin
        unique case ({exm_hit, mwb_hit})
            2'b10, 2'b11: sel = FWD_EXMEM;
            2'b01:        sel = FWD_WB;
            default:      sel = FWD_REGFILE;
        endcase
    end

endmodule

// File: rtl/fwd_wb_value.sv
module fwd_wb_value #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              mem2reg,
    input  logic [DATA_W-1:0] alu_val,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] wb_val
);

    always_comb begin
        wb_val = mem2reg ? load_val : alu_val;
    end

endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] wb_val,
    input  logic [DATA_W-1:0] exm_val,
    output logic [DATA_W-1:0] opnd
);

    // Code 3 falls to the register-file value.
    always_comb begin
        unique case (sel)
            2'd2:    opnd = exm_val;
            2'd1:    opnd = wb_val;
            default: opnd = rf_val;
        endcase
    end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int unsigned REG_W  = 5,
    parameter int unsigned DATA_W = 32
) (
    input  logic [REG_W-1:0]  ex_rs,
    input  logic [REG_W-1:0]  ex_rt,
    input  logic [DATA_W-1:0] rf_a,
    input  logic [DATA_W-1:0] rf_b,
    input  logic              exm_wen,
    input  logic [REG_W-1:0]  exm_rd,
    input  logic [DATA_W-1:0] exm_alu,
    input  logic              mwb_wen,
    input  logic [REG_W-1:0]  mwb_rd,
    input  logic [DATA_W-1:0] mwb_alu,
    input  logic [DATA_W-1:0] mwb_load,
    input  logic              mwb_mem2reg,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);

    localparam int unsigned NOP = FWD_OPERANDS;

    logic [REG_W-1:0]  src_v [NOP];
    logic [DATA_W-1:0] rf_v  [NOP];
    logic [1:0]        sel_v [NOP];
    logic [DATA_W-1:0] opn_v [NOP];
    logic [DATA_W-1:0] wb_val;

    always_comb begin
        src_v[0] = ex_rs;
        src_v[1] = ex_rt;
        rf_v[0]  = rf_a;
        rf_v[1]  = rf_b;
    end

    fwd_wb_value #(.DATA_W(DATA_W)) u_wb (
        .mem2reg  (mwb_mem2reg),
        .alu_val  (mwb_alu),
        .load_val (mwb_load),
        .wb_val   (wb_val)
    );

    for (genvar g = 0; g < NOP; g++) begin : g_opnd
        fwd_sel_e sel_e;

        fwd_match #(.REG_W(REG_W)) u_match (
            .src     (src_v[g]),
            .exm_wen (exm_wen),
            .exm_rd  (exm_rd),
            .mwb_wen (mwb_wen),
            .mwb_rd  (mwb_rd),
            .sel     (sel_e)
        );

        always_comb sel_v[g] = sel_e;

        fwd_operand_mux #(.DATA_W(DATA_W)) u_mux (
            .sel     (sel_v[g]),
            .rf_val  (rf_v[g]),
            .wb_val  (wb_val),
            .exm_val (exm_alu),
            .opnd    (opn_v[g])
        );
    end

    always_comb begin
        sel_a  = sel_v[0];
        sel_b  = sel_v[1];
        opnd_a = opn_v[0];
        opnd_b = opn_v[1];
    end

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
    parameter int unsigned REG_W  = 5,
    parameter int unsigned DATA_W = 32
) (
    input logic [REG_W-1:0]  ex_rs,
    input logic [REG_W-1:0]  ex_rt,
    input logic [DATA_W-1:0] rf_a,
    input logic [DATA_W-1:0] rf_b,
    input logic              exm_wen,
    input logic [REG_W-1:0]  exm_rd,
    input logic [DATA_W-1:0] exm_alu,
    input logic              mwb_wen,
    input logic [REG_W-1:0]  mwb_rd,
    input logic [DATA_W-1:0] mwb_alu,
    input logic [DATA_W-1:0] mwb_load,
    input logic              mwb_mem2reg,
    input logic [1:0]        sel_a,
    input logic [1:0]        sel_b,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b
);

    always_comb begin
        AST_A_EXM_QUAL: assert (sel_a != 2'd2 || (exm_wen && exm_rd == ex_rs && exm_rd != '0)) else $error("exm bypass A unqualified"); // R1
        AST_B_EXM_QUAL: assert (sel_b != 2'd2 || (exm_wen && exm_rd == ex_rt && exm_rd != '0)) else $error("exm bypass B unqualified"); // R1
        AST_A_WB_QUAL: assert (sel_a != 2'd1 || (mwb_wen && mwb_rd == ex_rs && mwb_rd != '0)) else $error("wb bypass A unqualified"); // R2
        AST_A_PRIORITY: assert (!(exm_wen && exm_rd == ex_rs && exm_rd != '0) || sel_a == 2'd2) else $error("younger result lost on A"); // R3
        AST_B_PRIORITY: assert (!(exm_wen && exm_rd == ex_rt && exm_rd != '0) || sel_b == 2'd2) else $error("younger result lost on B"); // R3
        AST_NO_CODE3: assert (sel_a != 2'd3 && sel_b != 2'd3) else $error("reserved select code"); // R5
        AST_A_EXM_DATA: assert (sel_a != 2'd2 || opnd_a == exm_alu) else $error("operand A data"); // R6
        AST_B_RF_DATA: assert (sel_b != 2'd0 || opnd_b == rf_b) else $error("operand B data"); // R6
        AST_A_WB_DATA: assert (sel_a != 2'd1 || opnd_a == (mwb_mem2reg ? mwb_load : mwb_alu)) else $error("writeback data"); // R7
    end

    logic unused_ok;
    always_comb unused_ok = ^{rf_a};

endmodule

bind fwd_unit fwd_unit_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/fwd_unit_bench.sv
module fwd_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  ex_rs = '0, ex_rt = '0, exm_rd = '0, mwb_rd = '0;
    logic        exm_wen = 1'b0, mwb_wen = 1'b0, mwb_mem2reg = 1'b0;
    logic [31:0] rf_a = '0, rf_b = '0, exm_alu = '0, mwb_alu = '0, mwb_load = '0;
    logic [1:0]  sel_a, sel_b;
    logic [31:0] opnd_a, opnd_b;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fwd_unit u_fwd_unit (.*);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            failures = failures + 1;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic int ref_sel(input int src, input int erd, input bit ew,
                                   input int mrd, input bit mw);
        if (ew && erd == src && erd != 0) return 2;
        if (mw && mrd == src && mrd != 0) return 1;
        return 0;
    endfunction

    function automatic string tag_for(input int src, input int erd, input bit ew,
                                      input int mrd, input bit mw, input int s);
        if (s == 2 && mw && mrd == src) return "R3";
        if (s == 2) return "R1";
        if (s == 1) return "R2";
        if ((ew && erd == src && erd == 0) || (mw && mrd == src && mrd == 0)) return "R4";
        return "R5";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        int pick[4] = '{0, 1, 5, 31};
        int n = 0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state: all-zero inputs give the register-file path (R5)
        check("R5", {30'd0, sel_a}, 32'd0);
        check("R5", {30'd0, sel_b}, 32'd0);
        for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
        for (int e = 0; e < 4; e++)
        for (int m = 0; m < 4; m++)
        for (int f = 0; f < 8; f++) begin
            int sa, sb;
            logic [31:0] wbv, ea, eb;
            @(posedge clk);
            n = n + 1;
            ex_rs = 5'(pick[a]);  ex_rt = 5'(pick[b]);
            exm_rd = 5'(pick[e]); mwb_rd = 5'(pick[m]);
            exm_wen = f[0]; mwb_wen = f[1]; mwb_mem2reg = f[2];
            rf_a = 32'hA000_0000 + n; rf_b = 32'hB000_0000 + n;
            exm_alu = 32'hE000_0000 + n; mwb_alu = 32'hC000_0000 + n;
            mwb_load = 32'hD000_0000 + n;
            sa = ref_sel(pick[a], pick[e], f[0], pick[m], f[1]);
            sb = ref_sel(pick[b], pick[e], f[0], pick[m], f[1]);
            wbv = f[2] ? mwb_load : mwb_alu;
            ea = (sa == 2) ? exm_alu : (sa == 1) ? wbv : rf_a;
            eb = (sb == 2) ? exm_alu : (sb == 1) ? wbv : rf_b;
            @(negedge clk);
            check(tag_for(pick[a], pick[e], f[0], pick[m], f[1], sa), {30'd0, sel_a}, 32'(sa));
            // operand B resolved on its own (R8)
            check(tag_for(pick[b], pick[e], f[0], pick[m], f[1], sb), {30'd0, sel_b}, 32'(sb));
            check((sa == 1) ? "R7" : "R6", opnd_a, ea);
            check((sb == 1) ? "R7" : "R8", opnd_b, eb);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule